// File: doc/BRIEF.md
# Interrupt Exception Entry Controller

This block decides when a 32-bit core enters an interrupt exception, and it performs that entry. Two request lines reach it, a high-priority level (INT2) and a lower one (INT1). Each request is tested against a global mask bit and against a mask bit for its own level, all held in the status register that this block owns. The block never flushes work already in the pipeline. An unmasked request is taken only in a cycle where the core reports that its in-flight instructions have retired.

On acceptance the block does four things. It raises a one-cycle accept strobe together with a level code. It presents the handler address as the sum of a vector base and an externally supplied vector offset. It copies the current status word and the resume address into a save bank that belongs to the accepted level. In the same clock edge it rewrites the mode, mask and flag fields of the status register.

The core's own write path can load the status register directly, for example when it restores a saved value. Status field positions are: R at bit 15, GM at bit 16, I0M at bit 17, I1M at bit 18, I2M at bit 19, mode at bits 24:22, and J at bit 28.

Top module: `irq_entry_ctrl`

## Requirements
- R1: A synchronous active-high reset sets the status register to 32'h0001_0000 (GM only) and clears both save banks. `accept` is low while GM is set.
- R2: An INT2 request is not taken while status bit 16 (GM) or bit 19 (I2M) is 1.
- R3: An INT1 request is not taken while status bit 16 (GM) or bit 18 (I1M) is 1.
- R4: When both levels are requested and unmasked in the same cycle, INT2 is taken.
- R5: A request is taken only in a cycle where `pipe_drained` is 1. In that cycle `accept` is 1 and `accept_level` shows the level (2'b10 for INT2, 2'b01 for INT1); otherwise `accept` is 0 and `accept_level` is 2'b00.
- R6: Taking INT2 copies the status register into `save_sr_l2` and `resume_addr` into `save_ra_l2` at the closing edge. The INT1 bank keeps its contents.
- R7: Taking INT1 copies the status register into `save_sr_l1` and `resume_addr` into `save_ra_l1` at the closing edge. The INT2 bank keeps its contents.
- R8: Taking INT2 clears bits 15 and 28, writes 3'b100 to bits 24:22, and sets bits 17, 18 and 19. Every other status bit keeps its value.
- R9: Taking INT1 clears bits 15 and 28, writes 3'b011 to bits 24:22, and sets bits 17 and 18. Bit 19 and every other status bit keep their values.
- R10: During the accept cycle, `target_pc` equals `vec_base + vec_offset` modulo 2^32.
- R11: With `sr_wr_en` high, the status register loads `sr_wr_data` at the next edge. In an accept cycle the write is ignored, and the entry update of R8/R9 applies instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| int2_req | input | 1 | High-priority interrupt request |
| int1_req | input | 1 | Low-priority interrupt request |
| pipe_drained | input | 1 | In-flight instructions have completed |
| resume_addr | input | 32 | Address of first non-completed instruction |
| vec_base | input | 32 | Exception vector base |
| vec_offset | input | 32 | Vector offset from the interrupt controller |
| sr_wr_en | input | 1 | Core write strobe for the status register |
| sr_wr_data | input | 32 | Status value to write |
| accept | output | 1 | One-cycle entry strobe |
| accept_level | output | 2 | Level taken: 10 INT2, 01 INT1, 00 none |
| target_pc | output | 32 | Handler address, valid with accept |
| status | output | 32 | Current status register |
| save_sr_l1 | output | 32 | Saved status for INT1 |
| save_ra_l1 | output | 32 | Saved return address for INT1 |
| save_sr_l2 | output | 32 | Saved status for INT2 |
| save_ra_l2 | output | 32 | Saved return address for INT2 |

## Verification
The assertions watch several properties on every cycle. The global mask and an undrained pipeline always block entry. At most one level is ever granted, and INT2 wins whenever it is eligible. Each entry leaves the expected mode and mask bits behind, and a save bank never moves without an accept at its level. Some properties can only be shown by the bench's sweep over every combination of mask bits, requests and drain state: that untouched status bits survive entry exactly, that the saved words match the values held before entry, that the handler address wraps, and that a status write colliding with entry is dropped.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
   localparam int SR_W    = 32;
   localparam int SR_R    = 15;
   localparam int SR_GM   = 16;
   localparam int SR_I0M  = 17;
   localparam int SR_I1M  = 18;
   localparam int SR_I2M  = 19;
   localparam int SR_M_LO = 22;
   localparam int SR_J    = 28;
   localparam int NUM_LVL = 2;

   typedef enum logic [1:0] {
      LVL_NONE = 2'b00,
      LVL_1    = 2'b01,
      LVL_2    = 2'b10
   } lvl_e;

   // Status word produced by entering the given level.
   function automatic logic [SR_W-1:0] sr_on_entry(input logic [SR_W-1:0] cur, input lvl_e lvl);
      logic [SR_W-1:0] n;
      n          = cur;
      n[SR_R]    = 1'b0;
      n[SR_J]    = 1'b0;
      n[SR_I0M]  = 1'b1;
      n[SR_I1M]  = 1'b1;
      if (lvl == LVL_2) begin
         n[SR_I2M]       = 1'b1;
         n[SR_M_LO +: 3] = 3'b100;
      end else begin
         n[SR_M_LO +: 3] = 3'b011;
      end
      return n;
   endfunction
endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter
   import irq_entry_pkg::*;
(
   input  logic            int2_req,
   input  logic            int1_req,
   input  logic            drained,
   input  logic [SR_W-1:0] sr,
   output logic            take,
   output lvl_e            lvl
);
   logic ok2, ok1;

   always_comb begin
      ok2 = int2_req & ~sr[SR_GM] & ~sr[SR_I2M];
      ok1 = int1_req & ~sr[SR_GM] & ~sr[SR_I1M];
      lvl = LVL_NONE;
      if (drained) begin
         if (ok2)      lvl = LVL_2;
         else if (ok1) lvl = LVL_1;
      end
      take = (lvl != LVL_NONE);
   end
endmodule

// File: rtl/irq_save_bank.sv
module irq_save_bank
   import irq_entry_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic [SR_W-1:0]   sr_in,
   input  logic [ADDR_W-1:0] ra_in,
   output logic [SR_W-1:0]   sr_q,
   output logic [ADDR_W-1:0] ra_q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         sr_q <= '0;
         ra_q <= '0;
      end else if (we) begin
         sr_q <= sr_in;
         ra_q <= ra_in;
      end
   end

   p_bank_hold_r6: assert property (@(posedge clk) disable iff (rst)
      !we |=> ($stable(sr_q) && $stable(ra_q)));
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
   import irq_entry_pkg::*;
(
   input  logic            clk,
   input  logic            rst,
   input  logic            enter,
   input  lvl_e            lvl,
   input  logic            wr_en,
   input  logic [SR_W-1:0] wr_data,
   output logic [SR_W-1:0] sr_q
);
   localparam logic [SR_W-1:0] SR_RESET = SR_W'(1) << SR_GM;

   always_ff @(posedge clk) begin
      if (rst)        sr_q <= SR_RESET;
      else if (enter) sr_q <= sr_on_entry(sr_q, lvl);
      else if (wr_en) sr_q <= wr_data;
   end

   p_entry_mode_r8: assert property (@(posedge clk) disable iff (rst)
      (enter && lvl == LVL_2) |=> (sr_q[SR_M_LO +: 3] == 3'b100 && sr_q[SR_I2M] && sr_q[SR_I1M] && sr_q[SR_I0M] && !sr_q[SR_R] && !sr_q[SR_J]));
   p_entry_mode_r9: assert property (@(posedge clk) disable iff (rst)
      (enter && lvl == LVL_1) |=> (sr_q[SR_M_LO +: 3] == 3'b011 && sr_q[SR_I2M] == $past(sr_q[SR_I2M]) && sr_q[SR_I1M] && sr_q[SR_I0M]));
   p_sr_idle_r11: assert property (@(posedge clk) disable iff (rst)
      (!enter && !wr_en) |=> $stable(sr_q));
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
   import irq_entry_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              int2_req,
   input  logic              int1_req,
   input  logic              pipe_drained,
   input  logic [ADDR_W-1:0] resume_addr,
   input  logic [ADDR_W-1:0] vec_base,
   input  logic [ADDR_W-1:0] vec_offset,
   input  logic              sr_wr_en,
   input  logic [SR_W-1:0]   sr_wr_data,
   output logic              accept,
   output logic [1:0]        accept_level,
   output logic [ADDR_W-1:0] target_pc,
   output logic [SR_W-1:0]   status,
   output logic [SR_W-1:0]   save_sr_l1,
   output logic [ADDR_W-1:0] save_ra_l1,
   output logic [SR_W-1:0]   save_sr_l2,
   output logic [ADDR_W-1:0] save_ra_l2
);
   if (ADDR_W < 8 || ADDR_W > 64) begin : g_bad_addr_w
      $error("irq_entry_ctrl: ADDR_W out of range");
   end

   lvl_e lvl;
   logic take;
   logic [SR_W-1:0]   bank_sr [NUM_LVL];
   logic [ADDR_W-1:0] bank_ra [NUM_LVL];

   irq_arbiter u_arb (
      .int2_req (int2_req),
      .int1_req (int1_req),
      .drained  (pipe_drained),
      .sr       (status),
      .take     (take),
      .lvl      (lvl)
   );

   irq_status_reg u_sr (
      .clk     (clk),
      .rst     (rst),
      .enter   (take),
      .lvl     (lvl),
      .wr_en   (sr_wr_en),
      .wr_data (sr_wr_data),
      .sr_q    (status)
   );

   for (genvar g = 0; g < NUM_LVL; g++) begin : g_bank
      irq_save_bank #(.ADDR_W(ADDR_W)) u_bank (
         .clk   (clk),
         .rst   (rst),
         .we    (take && lvl == lvl_e'(2'(g + 1))),
         .sr_in (status),
         .ra_in (resume_addr),
         .sr_q  (bank_sr[g]),
         .ra_q  (bank_ra[g])
      );
   end

   assign accept       = take;
   assign accept_level = lvl;
   assign target_pc    = vec_base + vec_offset;
   assign save_sr_l1   = bank_sr[0];
   assign save_ra_l1   = bank_ra[0];
   assign save_sr_l2   = bank_sr[1];
   assign save_ra_l2   = bank_ra[1];

   p_gm_blocks_r2: assert property (@(posedge clk) disable iff (rst)
      status[SR_GM] |-> !accept);
   p_i1m_blocks_r3: assert property (@(posedge clk) disable iff (rst)
      (status[SR_I1M] && !int2_req) |-> !accept);
   p_int2_wins_r4: assert property (@(posedge clk) disable iff (rst)
      (pipe_drained && int2_req && !status[SR_GM] && !status[SR_I2M]) |-> accept_level == 2'b10);
   p_wait_drain_r5: assert property (@(posedge clk) disable iff (rst)
      !pipe_drained |-> (!accept && accept_level == 2'b00));
   p_one_level_r5: assert property (@(posedge clk) disable iff (rst)
      $onehot0(accept_level));
   p_save_ra2_r6: assert property (@(posedge clk) disable iff (rst)
      (accept && accept_level == 2'b10) |=> save_ra_l2 == $past(resume_addr));
   p_save_sr1_r7: assert property (@(posedge clk) disable iff (rst)
      (accept && accept_level == 2'b01) |=> save_sr_l1 == $past(status));
endmodule

// File: tb/test_irq_entry_ctrl.sv
module test_irq_entry_ctrl;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst;
   logic        int2_req, int1_req, pipe_drained, sr_wr_en;
   logic [31:0] resume_addr, vec_base, vec_offset, sr_wr_data;
   logic        accept;
   logic [1:0]  accept_level;
   logic [31:0] target_pc, status, save_sr_l1, save_ra_l1, save_sr_l2, save_ra_l2;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   irq_entry_ctrl i_irq_entry_ctrl (
      .clk (clk), .rst (rst), .int2_req (int2_req), .int1_req (int1_req),
      .pipe_drained (pipe_drained), .resume_addr (resume_addr),
      .vec_base (vec_base), .vec_offset (vec_offset),
      .sr_wr_en (sr_wr_en), .sr_wr_data (sr_wr_data),
      .accept (accept), .accept_level (accept_level), .target_pc (target_pc),
      .status (status), .save_sr_l1 (save_sr_l1), .save_ra_l1 (save_ra_l1),
      .save_sr_l2 (save_sr_l2), .save_ra_l2 (save_ra_l2)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] entry_val(input logic [31:0] s, input bit hi);
      logic [31:0] n;
      n = s & ~(32'h1 << 15) & ~(32'h1 << 28) & ~(32'h7 << 22);
      n = n | (32'h3 << 17);
      if (hi) n = n | (32'h1 << 19) | (32'h4 << 22);
      else    n = n | (32'h3 << 22);
      return n;
   endfunction

   task automatic write_sr(input logic [31:0] v);
      @(negedge clk);
      sr_wr_en = 1'b1; sr_wr_data = v;
      @(negedge clk);
      sr_wr_en = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++; checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; int2_req = 0; int1_req = 0; pipe_drained = 0; sr_wr_en = 0;
      resume_addr = 0; vec_base = 0; vec_offset = 0; sr_wr_data = 0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1: reset state
      chk(status == 32'h0001_0000, "R1 status", status, 32'h0001_0000);
      chk(save_sr_l1 == 0 && save_ra_l1 == 0 && save_sr_l2 == 0 && save_ra_l2 == 0,
          "R1 banks", save_sr_l2, 0);
      int2_req = 1; int1_req = 1; pipe_drained = 1; #2;
      chk(!accept, "R1 gm blocks after reset", {31'b0, accept}, 0);
      @(negedge clk); int2_req = 0; int1_req = 0;

      for (int idx = 0; idx < 64; idx++) begin
         bit gm, m2, m1, r2, r1, dr, ok2, ok1, t2, t1;
         logic [31:0] s0, p1s, p1a, p2s, p2a;
         logic [1:0] elvl;
         gm = idx[0]; m2 = idx[1]; m1 = idx[2]; r2 = idx[3]; r1 = idx[4]; dr = idx[5];
         s0 = 32'h4000_0201 | (32'h1 << 15) | (32'h1 << 28) | (32'h1 << 22) | (32'(idx) << 4)
              | (32'(gm) << 16) | (32'(m1) << 18) | (32'(m2) << 19);
         write_sr(s0);
         chk(status == s0, "R11 sr write", status, s0);
         p1s = save_sr_l1; p1a = save_ra_l1; p2s = save_sr_l2; p2a = save_ra_l2;
         int2_req = r2; int1_req = r1; pipe_drained = dr;
         resume_addr = 32'h1000_0000 + 32'(idx * 4);
         vec_base = 32'h8000_0000; vec_offset = 32'(idx * 16);
         ok2 = r2 && !gm && !m2; ok1 = r1 && !gm && !m1;
         t2 = dr && ok2; t1 = dr && ok1 && !ok2;
         elvl = t2 ? 2'b10 : (t1 ? 2'b01 : 2'b00);
         #2;
         // R2 R3 R4 R5: acceptance and level code
         chk(accept == (t2 || t1) && accept_level == elvl, "R2/R3/R4/R5 accept",
             {29'b0, accept, accept_level}, {29'b0, (t2 || t1), elvl});
         if (t2 || t1)
            chk(target_pc == 32'h8000_0000 + 32'(idx * 16), "R10 target", target_pc,
                32'h8000_0000 + 32'(idx * 16));
         @(negedge clk);
         int2_req = 0; int1_req = 0; pipe_drained = 0;
         if (t2) begin
            chk(status == entry_val(s0, 1'b1), "R8 sr int2", status, entry_val(s0, 1'b1));
            chk(save_sr_l2 == s0 && save_ra_l2 == 32'h1000_0000 + 32'(idx * 4), "R6 bank2",
                save_ra_l2, 32'h1000_0000 + 32'(idx * 4));
            chk(save_sr_l1 == p1s && save_ra_l1 == p1a, "R6 bank1 kept", save_sr_l1, p1s);
         end else if (t1) begin
            chk(status == entry_val(s0, 1'b0), "R9 sr int1", status, entry_val(s0, 1'b0));
            chk(save_sr_l1 == s0 && save_ra_l1 == 32'h1000_0000 + 32'(idx * 4), "R7 bank1",
                save_sr_l1, s0);
            chk(save_sr_l2 == p2s && save_ra_l2 == p2a, "R7 bank2 kept", save_sr_l2, p2s);
         end else begin
            chk(status == s0, "R2/R3/R5 sr unchanged", status, s0);
            chk(save_sr_l1 == p1s && save_ra_l1 == p1a && save_sr_l2 == p2s && save_ra_l2 == p2a,
                "R2/R3/R5 banks unchanged", save_ra_l2, p2a);
         end
      end

      // R10: carry out of the sum is discarded
      write_sr(32'h0000_0000);
      vec_base = 32'hFFFF_FF00; vec_offset = 32'h0000_0200;
      int1_req = 1; pipe_drained = 1; #2;
      chk(accept && target_pc == 32'h0000_0100, "R10 wrap", target_pc, 32'h0000_0100);
      @(negedge clk); int1_req = 0; pipe_drained = 0;

      // R11: status write colliding with an entry is dropped
      write_sr(32'h1000_8000);
      int2_req = 1; pipe_drained = 1; sr_wr_en = 1; sr_wr_data = 32'hFFFF_FFFF;
      @(negedge clk);
      int2_req = 0; pipe_drained = 0; sr_wr_en = 0;
      chk(status == entry_val(32'h1000_8000, 1'b1), "R11 write dropped on entry", status,
          entry_val(32'h1000_8000, 1'b1));

      // R9: I2M stays clear after an INT1 entry, so INT2 can still preempt
      write_sr(32'h0000_0000);
      int1_req = 1; pipe_drained = 1;
      @(negedge clk); int1_req = 0;
      chk(status[19] == 1'b0, "R9 i2m kept", status, 32'h0);
      int2_req = 1; #2;
      chk(accept && accept_level == 2'b10, "R4 nested int2", {30'b0, accept_level}, 32'h2);
      @(negedge clk); int2_req = 0; pipe_drained = 0;

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule